// File: doc/BRIEF.md
# Two-Port Word Memory with Port-B Write Priority

This block is a parameterized memory of 2^ADDR_W words, each DATA_W bits wide, reached through two independent ports, A and B, that share one clock. Each port has its own address, write data, store strobe, lane enables, load (output drive) strobe and read data. Both ports may read or write in the same cycle, including at the same address.

Reads are combinational. A port's read data shows the word at its address while its load strobe is high, and is released to high impedance while the load strobe is low. Writes take effect on the rising clock edge. When lane writes are enabled, each word is split into 8-bit lanes from bit 0 upward, and a store only changes the lanes whose enable bit is set. A clear input wipes the whole array asynchronously and overrides any write.

When both ports write the same word in one cycle, port B decides every lane it enables, and port A keeps only the lanes that it alone enables. The block suits register files, mailboxes and shared scratch memories where two agents work on one word store.

Top module: `dpr_ram_2p`

## Requirements
- R1: While `wipe` is 1, every word reads as zero at once, without waiting for a clock edge. After `wipe` returns to 0, each word stays zero until it is written.
- R2: When `a_store` is 1 and `wipe` is 0, the rising edge of `clk` writes the enabled lanes of `a_wdata` into the word at `a_addr`.
- R3: When `b_store` is 1 and `wipe` is 0, the rising edge of `clk` writes the enabled lanes of `b_wdata` into the word at `b_addr`.
- R4: If both ports store to the same address in one cycle, each lane that `b_lanes` enables takes port B's data. Each lane that only `a_lanes` enables takes port A's data. Each lane that neither port enables keeps its old value.
- R5: If both ports store to different addresses in one cycle, both words are written.
- R6: Read data is combinational from the addressed word and write-first. After a write edge, either port that reads the written address returns the new value, whichever port made the write.
- R7: While a port's load strobe is 0, its read data output is high impedance. While the load strobe is 1, the output carries the addressed word.
- R8: With lane writes enabled (LANE_WR=1 and DATA_W of 9 or more), enable bit i gates bits [8i+7:8i]. The top lane covers only the bits that remain, so with DATA_W=20 bit 2 gates bits [19:16]. With lane writes disabled, every store writes the full word and the enable inputs are ignored.
- R9: A cycle whose store strobe is 0 changes no word, whatever that port's data and lane enables are.
- R10: A store made while `wipe` is 1 has no effect. The word still reads zero after `wipe` is released.
- R11: A store with all lane enables at 0 leaves the word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports; writes on the rising edge |
| wipe | input | 1 | Asynchronous clear of the whole array, active high |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_store | input | 1 | Port A write strobe |
| a_lanes | input | ceil(DATA_W/8) | Port A lane write enables |
| a_load | input | 1 | Port A output drive enable |
| a_rdata | output | DATA_W | Port A read data, high impedance when not loading |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_store | input | 1 | Port B write strobe |
| b_lanes | input | ceil(DATA_W/8) | Port B lane write enables |
| b_load | input | 1 | Port B output drive enable |
| b_rdata | output | DATA_W | Port B read data, high impedance when not loading |

## Verification
Random traffic is confined mostly to eight addresses, so that same-address collisions with mixed lane masks happen often. A reference array checks both read ports after every edge. Directed collisions then separate the lane-by-lane merge from a whole-word winner: full overlap, disjoint lanes, and lanes enabled by port A only. Writes through only the narrow top lane check that lanes are placed by position. Idle cycles with busy data and lane inputs, and stores with all enables at 0, show that a store strobe and a lane enable are each required. Load-low reads on a pulled-up net can be told apart from a driven word of zeros. Stores and clocks during a clear show that the clear takes priority.

// File: rtl/dpr_pkg.sv
`timescale 1ns/1ps
package dpr_pkg;

  // number of 8-bit lanes needed to cover a word
  function automatic int lanes_of(input int dw);
    return (dw + 7) / 8;
  endfunction

  // lowest bit of lane l
  function automatic int lane_lo(input int l);
    return l * 8;
  endfunction

  // highest bit of lane l, clipped to the word
  function automatic int lane_hi(input int l, input int dw);
    return ((l * 8 + 7) < dw) ? (l * 8 + 7) : (dw - 1);
  endfunction

  // lane writes exist only for words wider than one byte
  function automatic bit lanes_active(input bit requested, input int dw);
    return requested && (dw >= 9);
  endfunction

endpackage

// File: rtl/dpr_lane_mask.sv
`timescale 1ns/1ps
module dpr_lane_mask #(
  parameter int DATA_W  = 20,
  parameter bit LANE_WR = 1'b1
) (
  input  logic [dpr_pkg::lanes_of(DATA_W)-1:0] lanes,
  output logic [DATA_W-1:0]                    bit_mask
);
  import dpr_pkg::*;

  localparam int NLANE = lanes_of(DATA_W);

  logic [NLANE-1:0] lane_on;

  generate
    if (lanes_active(LANE_WR, DATA_W)) begin : g_masked
      assign lane_on = lanes;
    end else begin : g_full
      // enables are ignored: every store covers the whole word
      logic unused_lanes;
      assign unused_lanes = ^lanes;
      assign lane_on = '1;
    end
  endgenerate

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    localparam int LO = lane_lo(l);
    localparam int HI = lane_hi(l, DATA_W);
    assign bit_mask[HI:LO] = {(HI - LO + 1){lane_on[l]}};
  end

endmodule

// File: rtl/dpr_store.sv
`timescale 1ns/1ps
module dpr_store #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 20
) (
  input  logic              clk,
  input  logic              wipe,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  input  logic              a_store,
  input  logic [DATA_W-1:0] a_mask,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  input  logic              b_store,
  input  logic [DATA_W-1:0] b_mask,
  output logic [DATA_W-1:0] a_word,
  output logic [DATA_W-1:0] b_word
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // named internal events
  logic              same_word;
  logic              collide;
  logic [DATA_W-1:0] a_next;
  logic [DATA_W-1:0] b_base;
  logic [DATA_W-1:0] b_next;

  function automatic logic [DATA_W-1:0] merge_lanes(
    input logic [DATA_W-1:0] old_w,
    input logic [DATA_W-1:0] new_w,
    input logic [DATA_W-1:0] m
  );
    return (old_w & ~m) | (new_w & m);
  endfunction

  assign same_word = (a_addr == b_addr);
  assign collide   = a_store && b_store && same_word;

  assign a_next = merge_lanes(mem[a_addr], a_wdata, a_mask);
  // on a collision port B lands on top of port A's merged word
  assign b_base = collide ? a_next : mem[b_addr];
  assign b_next = merge_lanes(b_base, b_wdata, b_mask);

  always_ff @(posedge clk or posedge wipe) begin
    if (wipe) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (a_store) mem[a_addr] <= a_next;
      if (b_store) mem[b_addr] <= b_next;
    end
  end

  assign a_word = mem[a_addr];
  assign b_word = mem[b_addr];

  // ---------------- assertions ----------------
  always @(posedge clk) begin
    if (wipe) begin
      p_clear_zero_r1: assert (mem[a_addr] == '0 && mem[b_addr] == '0)
        else $error("array not zero while clear is held");
    end
  end

  // port A lanes that port B does not also claim must land
  p_a_write_r2: assert property (@(posedge clk) disable iff (wipe)
    a_store |=> (((mem[$past(a_addr)] ^ $past(a_wdata)) &
                 $past(a_mask & ~(collide ? b_mask : '0))) == '0))
    else $error("port A write lost");

  // port B lanes always land, also over a colliding port A write (R4)
  p_b_write_r3: assert property (@(posedge clk) disable iff (wipe)
    b_store |=> (((mem[$past(b_addr)] ^ $past(b_wdata)) & $past(b_mask)) == '0))
    else $error("port B write lost");

  // lanes enabled by neither colliding port keep their value
  p_idle_lanes_r4: assert property (@(posedge clk) disable iff (wipe)
    collide |=> (((mem[$past(a_addr)] ^ $past(mem[a_addr])) &
                 $past(~(a_mask | b_mask))) == '0))
    else $error("untouched lanes changed in collision");

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (wipe)
    (!a_store && !b_store) |=> (mem[$past(a_addr)] == $past(mem[a_addr])))
    else $error("word changed without a store");

endmodule

// File: rtl/dpr_read_port.sv
`timescale 1ns/1ps
module dpr_read_port #(
  parameter int DATA_W = 20
) (
  input  logic              wipe,
  input  logic              load,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] shown,
  output logic              drive
);

  // clear forces zero even in the same instant the array is being wiped
  assign shown = wipe ? '0 : word;
  assign drive = load;

endmodule

// File: rtl/dpr_ram_2p.sv
`timescale 1ns/1ps
module dpr_ram_2p #(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 20,
  parameter bit LANE_WR = 1'b1
) (
  input  logic                          clk,
  input  logic                          wipe,
  input  logic [ADDR_W-1:0]             a_addr,
  input  logic [DATA_W-1:0]             a_wdata,
  input  logic                          a_store,
  input  logic [(DATA_W+7)/8-1:0]       a_lanes,
  input  logic                          a_load,
  output logic [DATA_W-1:0]             a_rdata,
  input  logic [ADDR_W-1:0]             b_addr,
  input  logic [DATA_W-1:0]             b_wdata,
  input  logic                          b_store,
  input  logic [(DATA_W+7)/8-1:0]       b_lanes,
  input  logic                          b_load,
  output logic [DATA_W-1:0]             b_rdata
);

  logic [DATA_W-1:0] a_mask, b_mask;
  logic [DATA_W-1:0] a_word, b_word;
  logic [DATA_W-1:0] a_shown, b_shown;
  logic              a_drive, b_drive;

  dpr_lane_mask #(.DATA_W(DATA_W), .LANE_WR(LANE_WR)) u_mask_a (
    .lanes(a_lanes), .bit_mask(a_mask)
  );
  dpr_lane_mask #(.DATA_W(DATA_W), .LANE_WR(LANE_WR)) u_mask_b (
    .lanes(b_lanes), .bit_mask(b_mask)
  );

  dpr_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk    (clk),
    .wipe   (wipe),
    .a_addr (a_addr),
    .a_wdata(a_wdata),
    .a_store(a_store),
    .a_mask (a_mask),
    .b_addr (b_addr),
    .b_wdata(b_wdata),
    .b_store(b_store),
    .b_mask (b_mask),
    .a_word (a_word),
    .b_word (b_word)
  );

  dpr_read_port #(.DATA_W(DATA_W)) u_rd_a (
    .wipe(wipe), .load(a_load), .word(a_word), .shown(a_shown), .drive(a_drive)
  );
  dpr_read_port #(.DATA_W(DATA_W)) u_rd_b (
    .wipe(wipe), .load(b_load), .word(b_word), .shown(b_shown), .drive(b_drive)
  );

  assign a_rdata = a_drive ? a_shown : 'z;
  assign b_rdata = b_drive ? b_shown : 'z;

endmodule

// File: tb/test_dpr_ram_2p.sv
`timescale 1ns/1ps
module test_dpr_ram_2p;

  localparam int AW = 6;
  localparam int DW = 20;
  localparam int NL = (DW + 7) / 8;
  localparam int DEPTH = 1 << AW;
  localparam logic [DW-1:0] PULLED = '1;

  logic clk = 1'b0;
  logic wipe = 1'b0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0;
  logic a_store = 1'b0, b_store = 1'b0, a_load = 1'b1, b_load = 1'b1;
  logic [NL-1:0] a_lanes = '1, b_lanes = '1;
  wire  [DW-1:0] a_rdata, b_rdata;

  int total = 0;
  int bad = 0;
  logic [DW-1:0] model [DEPTH];

  always #2 clk = ~clk;  // 250 MHz

  for (genvar g = 0; g < DW; g++) begin : g_pull
    pullup pu_a (a_rdata[g]);
    pullup pu_b (b_rdata[g]);
  end

  dpr_ram_2p #(.ADDR_W(AW), .DATA_W(DW), .LANE_WR(1'b1)) i_dpr_ram_2p (
    .clk(clk), .wipe(wipe),
    .a_addr(a_addr), .a_wdata(a_wdata), .a_store(a_store), .a_lanes(a_lanes),
    .a_load(a_load), .a_rdata(a_rdata),
    .b_addr(b_addr), .b_wdata(b_wdata), .b_store(b_store), .b_lanes(b_lanes),
    .b_load(b_load), .b_rdata(b_rdata)
  );

  // bit b belongs to lane b/8
  function automatic logic [DW-1:0] bits_of(input logic [NL-1:0] en);
    logic [DW-1:0] m;
    for (int b = 0; b < DW; b++) m[b] = en[b / 8];
    return m;
  endfunction

  function automatic logic [DW-1:0] put(input logic [DW-1:0] old_w,
                                        input logic [DW-1:0] d,
                                        input logic [NL-1:0] en);
    logic [DW-1:0] r;
    r = old_w;
    for (int b = 0; b < DW; b++) if (en[b / 8]) r[b] = d[b];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // drive one cycle at the falling edge, update model at the rising edge,
  // then look one ns later
  task automatic cycle();
    @(posedge clk);
    if (!wipe) begin
      if (a_store) model[a_addr] = put(model[a_addr], a_wdata, a_lanes);
      if (b_store) model[b_addr] = put(model[b_addr], b_wdata, b_lanes);
    end
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    a_store = 0; b_store = 0; a_load = 1; b_load = 1;
  endtask

  task automatic look(input string tag);
    chk(tag, a_rdata, a_load ? model[a_addr] : PULLED);
    chk(tag, b_rdata, b_load ? model[b_addr] : PULLED);
  endtask

  task automatic pulse_clear();
    @(negedge clk); #1 wipe = 1;
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    #0.5;
    a_addr = 5; b_addr = 6; a_load = 1; b_load = 1;
    #0.1 chk("R1 async", a_rdata, '0);
    chk("R1 async", b_rdata, '0);
    // store while clearing: must not land (R10)
    a_store = 1; a_wdata = 20'hABCDE; a_lanes = '1;
    b_store = 1; b_wdata = 20'h12345; b_lanes = '1;
    cycle(); cycle();
    @(negedge clk); a_store = 0; b_store = 0; wipe = 0;
    #1 chk("R10", a_rdata, '0);
    chk("R10", b_rdata, '0);
  endtask

  initial begin : watchdog
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    seed = $urandom(32'd2024);
    #1;
    pulse_clear();
    // R1: words untouched after clear read zero
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); a_addr = AW'(i * 9); b_addr = AW'(i * 9 + 1);
      #1 chk("R1 after", a_rdata, '0); chk("R1 after", b_rdata, '0);
    end

    // R2/R3/R5: separate full writes, cross-read shows each (R6)
    @(negedge clk);
    a_addr = 3; a_wdata = 20'h1F00D; a_store = 1; a_lanes = '1;
    b_addr = 4; b_wdata = 20'h0BEEF; b_store = 1; b_lanes = '1;
    cycle(); look("R5");
    idle(); a_addr = 4; b_addr = 3;
    #1 chk("R6 cross A", a_rdata, 20'h0BEEF); chk("R6 cross B", b_rdata, 20'h1F00D);

    // R4: full collision, B wins
    @(negedge clk);
    a_addr = 9; b_addr = 9; a_store = 1; b_store = 1;
    a_wdata = 20'hAAAAA; b_wdata = 20'h55555; a_lanes = '1; b_lanes = '1;
    cycle(); chk("R4 full", a_rdata, 20'h55555); chk("R4 full", b_rdata, 20'h55555);

    // R4: partial merge: A lanes 0,2 ; B lane 0 -> lane0 B, lane1 old, lane2 A
    @(negedge clk);
    a_wdata = 20'h11111; b_wdata = 20'h22222; a_lanes = 3'b101; b_lanes = 3'b001;
    cycle(); chk("R4 merge", a_rdata, 20'h15522); look("R4 merge");

    // R8: top lane only covers bits 19:16
    @(negedge clk);
    a_store = 1; b_store = 0; a_addr = 10; a_wdata = '1; a_lanes = 3'b100;
    cycle(); chk("R8 top lane", a_rdata, 20'hF0000);
    @(negedge clk); a_lanes = 3'b010; a_wdata = 20'h0A5C3;
    cycle(); chk("R8 mid lane", a_rdata, 20'hFA500);

    // R11: store with no lanes enabled
    @(negedge clk); a_lanes = '0; a_wdata = 20'h01234;
    cycle(); chk("R11", a_rdata, 20'hFA500);

    // R9: busy data and lanes without store
    @(negedge clk); a_store = 0; b_store = 0; a_lanes = '1; b_lanes = '1;
    b_addr = 10; a_wdata = 20'h77777; b_wdata = 20'h66666;
    cycle(); chk("R9 A", a_rdata, 20'hFA500); chk("R9 B", b_rdata, 20'hFA500);

    // R7: load low releases the bus (pulled high), even over a zero word
    @(negedge clk); a_load = 0; a_addr = 40; b_load = 1; b_addr = 40;
    #1 chk("R7 off", a_rdata, PULLED); chk("R7 on", b_rdata, '0);
    idle();

    // random traffic on a narrow address window
    for (int n = 0; n < 1500; n++) begin
      @(negedge clk);
      a_addr  = ($urandom_range(0, 3) == 0) ? AW'($urandom) : AW'($urandom_range(0, 7));
      b_addr  = ($urandom_range(0, 3) == 0) ? AW'($urandom) : AW'($urandom_range(0, 7));
      a_wdata = DW'($urandom); b_wdata = DW'($urandom);
      a_lanes = NL'($urandom); b_lanes = NL'($urandom);
      a_store = ($urandom_range(0, 2) != 0); b_store = ($urandom_range(0, 2) != 0);
      a_load  = ($urandom_range(0, 5) != 0); b_load  = ($urandom_range(0, 5) != 0);
      cycle();
      look("R6 random");
      if (n == 700) pulse_clear();
    end

    idle();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule